// File: doc/BRIEF.md
# Dual-Trellis Branch-Metric and Add-Compare-Select Core

This block is the metric engine of a rate-1/2 soft-decision Viterbi decoder. Each clock it can accept one pair of 3-bit soft symbols. It turns the pair into four branch metrics and then updates a bank of 8-bit path metrics through an array of radix-2 butterflies. For every state it reports the surviving metric and a one-bit decision that says which predecessor won. Survivor storage and traceback sit downstream and are not part of this block.

A single butterfly array covers two trellis sizes. In the small mode the code has constraint length 4 and 8 states. In the large mode it has constraint length 6 and 32 states. The mode is captured with the first symbol of each packet, and that symbol's start flag also reloads the metrics to a known starting point. The first four butterflies are shared between the two modes through input multiplexers. Metric growth is bounded by clearing the top bit of every live metric once all of them have it set. Which branch metric feeds each butterfly is set by parameter tables, so the block can serve different generator polynomials.

Top module: `dual_k_acs`

## Requirements
- R1: With a = `sym0` and b = `sym1` read as unsigned 3-bit values, the four branch metrics are index 0: a+b, index 1: a+(7-b), index 2: (7-a)+b and index 3: (7-a)+(7-b).
- R2: With N live states (8 or 32), butterfly i reads the metrics of states i and i+N/2 and writes states 2i (upper) and 2i+1 (lower). Parameter tables give two selections, s0 and s1, for each butterfly, with entry i held at bits [2i+1:2i]. The upper candidates are pm[i]+bm[s0] and pm[i+N/2]+bm[s1]. The lower candidates are pm[i]+bm[s1] and pm[i+N/2]+bm[s0].
- R3: Each new metric is the smaller of its two candidates. Its decision bit is 1 only when the candidate from state i+N/2 is strictly smaller, so a tie yields decision 0.
- R4: A symbol presented with `in_valid` and `start` both high is processed from reload metrics: state 0 at 0 and every other state at `INIT_BIG` (default 64). `start` without `in_valid` has no effect.
- R5: `mode` (0 = 8 states, 1 = 32 states) is sampled only on a symbol that carries `start`. That symbol and every later symbol up to the next start use the sampled mode, and the `mode` input is ignored on all other cycles.
- R6: In the 8-state mode, metrics and decisions of states 8 to 31 are reported as 0.
- R7: If every live new metric is 128 or more, 128 is subtracted from each live metric (the top bit is cleared) before it is stored.
- R8: For a symbol sampled at rising edge n, `out_valid`, `pm_out` and `dec_out` carry its result from rising edge n+2 onward. Back-to-back packets of different modes each keep their own mode.
- R9: On a cycle with `in_valid` low the stored metrics are held, no result is produced (`out_valid` low, outputs held), and the next symbol continues from the held metrics.
- R10: A synchronous active-low reset clears `out_valid`, `pm_out` and `dec_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Soft symbol pair present this cycle |
| start | input | 1 | First symbol of a packet (qualified by in_valid) |
| mode | input | 1 | Trellis select sampled at start: 0 = 8 states, 1 = 32 states |
| sym0 | input | 3 | First soft symbol |
| sym1 | input | 3 | Second soft symbol |
| out_valid | output | 1 | pm_out and dec_out hold a new result |
| pm_out | output | 256 | Path metric of state s at bits [8s+7:8s] |
| dec_out | output | 32 | Decision bit of state s at bit s |

## Verification
The case that matters most is a packet boundary where two things happen in the same clock. The last symbol of one packet is in the compare stage while the start symbol of the next packet, in the other mode, is in the branch-metric stage and is latching the new mode. The bench provokes this with chains of short packets that alternate mode and have no idle cycle between them. Every cycle it checks the outputs against a behavioural model that tracks the mode carried by each in-flight symbol. A per-state mode mix-up would show up either in the final outputs of the old packet or in the reload outputs of the new one.

// File: rtl/acs_pkg.sv
package acs_pkg;

    localparam int SYM_W   = 3;
    localparam int BM_W    = SYM_W + 1;
    localparam int NUM_BM  = 4;
    localparam int PM_W    = 8;
    localparam int SUM_W   = PM_W + 1;
    localparam int N_MAX   = 32;
    localparam int N_K4    = 8;
    localparam int N_BF    = N_MAX / 2;
    localparam int N_BF_K4 = N_K4 / 2;
    localparam int BM_MAX  = 2 * ((1 << SYM_W) - 1);

    typedef logic [BM_W-1:0] bm_t;
    typedef logic [PM_W-1:0] pm_t;
    typedef logic [N_MAX-1:0][PM_W-1:0] pm_vec_t;

    typedef struct packed {
        logic                   vld;
        logic                   first;
        logic                   k6;
        bm_t [NUM_BM-1:0]       bm;
    } bm_stage_t;

    function automatic bm_t soft_add(input logic [SYM_W-1:0] a, input logic [SYM_W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

endpackage

// File: rtl/acs_bm_stage.sv
module acs_bm_stage
    import acs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             start,
    input  logic             mode,
    input  logic [SYM_W-1:0] sym0,
    input  logic [SYM_W-1:0] sym1,
    output bm_stage_t        stg_q
);

    logic             md_q;
    logic             take_start;
    logic [SYM_W-1:0] inv0;
    logic [SYM_W-1:0] inv1;
    bm_stage_t        stg_d;

    assign take_start = in_valid & start;
    assign inv0       = ~sym0;
    assign inv1       = ~sym1;

    always_comb begin
        stg_d.vld   = in_valid;
        stg_d.first = take_start;
        stg_d.k6    = take_start ? mode : md_q;
        stg_d.bm[0] = soft_add(sym0, sym1);
        stg_d.bm[1] = soft_add(sym0, inv1);
        stg_d.bm[2] = soft_add(inv0, sym1);
        stg_d.bm[3] = soft_add(inv0, inv1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
            md_q  <= 1'b0;
        end else begin
            stg_q <= stg_d;
            if (take_start) begin
                md_q <= mode;
            end
        end
    end

    // R1
    bm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q.vld |-> (stg_q.bm[0] <= BM_W'(BM_MAX) && stg_q.bm[3] <= BM_W'(BM_MAX)));

endmodule

// File: rtl/acs_bfly.sv
module acs_bfly
    import acs_pkg::*;
(
    input  pm_t  pm_a,
    input  pm_t  pm_b,
    input  bm_t  bm_x,
    input  bm_t  bm_y,
    output pm_t  pm_up,
    output pm_t  pm_lo,
    output logic dec_up,
    output logic dec_lo,
    output logic ovf
);

    logic [SUM_W-1:0] up_a, up_b, lo_a, lo_b;
    logic [SUM_W-1:0] up_win, lo_win;

    always_comb begin
        up_a   = {1'b0, pm_a} + SUM_W'(bm_x);
        up_b   = {1'b0, pm_b} + SUM_W'(bm_y);
        lo_a   = {1'b0, pm_a} + SUM_W'(bm_y);
        lo_b   = {1'b0, pm_b} + SUM_W'(bm_x);
        dec_up = (up_b < up_a);
        dec_lo = (lo_b < lo_a);
        up_win = dec_up ? up_b : up_a;
        lo_win = dec_lo ? lo_b : lo_a;
        pm_up  = up_win[PM_W-1:0];
        pm_lo  = lo_win[PM_W-1:0];
        ovf    = up_win[PM_W] | lo_win[PM_W];
    end

endmodule

// File: rtl/acs_norm.sv
module acs_norm
    import acs_pkg::*;
#(
    parameter int N       = N_MAX,
    parameter int N_SMALL = N_K4
) (
    input  logic [N-1:0][PM_W-1:0] raw,
    input  logic                   k6,
    output logic [N-1:0][PM_W-1:0] cleaned,
    output logic                   cleared
);

    logic all_big;
    logic all_small;

    always_comb begin
        all_big   = 1'b1;
        all_small = 1'b1;
        for (int s = 0; s < N; s++) begin
            if (!raw[s][PM_W-1]) begin
                all_big = 1'b0;
                if (s < N_SMALL) begin
                    all_small = 1'b0;
                end
            end
        end
        cleared = k6 ? all_big : all_small;
        cleaned = raw;
        if (cleared) begin
            for (int s = 0; s < N; s++) begin
                cleaned[s][PM_W-1] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/dual_k_acs.sv
module dual_k_acs
    import acs_pkg::*;
#(
    parameter logic [2*N_BF-1:0]    BM_SEL0_K6 = 32'h639C639C,
    parameter logic [2*N_BF-1:0]    BM_SEL1_K6 = 32'h9C639C63,
    parameter logic [2*N_BF_K4-1:0] BM_SEL0_K4 = 8'hB4,
    parameter logic [2*N_BF_K4-1:0] BM_SEL1_K4 = 8'h4B,
    parameter logic [PM_W-1:0]      INIT_BIG   = 8'd64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  start,
    input  logic                  mode,
    input  logic [SYM_W-1:0]      sym0,
    input  logic [SYM_W-1:0]      sym1,
    output logic                  out_valid,
    output logic [N_MAX*PM_W-1:0] pm_out,
    output logic [N_MAX-1:0]      dec_out
);

    bm_stage_t        stg_q;
    pm_vec_t          pm_q;
    pm_vec_t          pm_src;
    pm_vec_t          init_vec;
    pm_vec_t          bf_pm;
    pm_vec_t          raw_m;
    pm_vec_t          pm_next;
    logic [N_MAX-1:0] bf_dec;
    logic [N_MAX-1:0] dec_m;
    logic [N_MAX-1:0] dec_q;
    logic [N_BF-1:0]  bf_ovf;
    logic             ovf_any;
    logic             norm_hit;
    logic             v2_q;
    logic             k6_2_q;
    pm_vec_t          out_pm_q;
    logic [N_MAX-1:0] out_dec_q;
    logic             out_v_q;

    acs_bm_stage u_bm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .start    (start),
        .mode     (mode),
        .sym0     (sym0),
        .sym1     (sym1),
        .stg_q    (stg_q)
    );

    always_comb begin
        for (int s = 0; s < N_MAX; s++) begin
            init_vec[s] = (s == 0) ? '0 : INIT_BIG;
        end
        pm_src = stg_q.first ? init_vec : pm_q;
    end

    for (genvar i = 0; i < N_BF; i++) begin : g_bf
        localparam logic [1:0] SX6 = BM_SEL0_K6[2*i +: 2];
        localparam logic [1:0] SY6 = BM_SEL1_K6[2*i +: 2];
        pm_t pm_b_in;
        bm_t bm_x_in;
        bm_t bm_y_in;

        if (i < N_BF_K4) begin : g_shared
            localparam logic [1:0] SX4 = BM_SEL0_K4[2*i +: 2];
            localparam logic [1:0] SY4 = BM_SEL1_K4[2*i +: 2];
            assign pm_b_in = stg_q.k6 ? pm_src[i + N_BF] : pm_src[i + N_BF_K4];
            assign bm_x_in = stg_q.k6 ? stg_q.bm[SX6] : stg_q.bm[SX4];
            assign bm_y_in = stg_q.k6 ? stg_q.bm[SY6] : stg_q.bm[SY4];
        end else begin : g_large_only
            assign pm_b_in = pm_src[i + N_BF];
            assign bm_x_in = stg_q.bm[SX6];
            assign bm_y_in = stg_q.bm[SY6];
        end

        acs_bfly u_bfly (
            .pm_a   (pm_src[i]),
            .pm_b   (pm_b_in),
            .bm_x   (bm_x_in),
            .bm_y   (bm_y_in),
            .pm_up  (bf_pm[2*i]),
            .pm_lo  (bf_pm[2*i+1]),
            .dec_up (bf_dec[2*i]),
            .dec_lo (bf_dec[2*i+1]),
            .ovf    (bf_ovf[i])
        );
    end

    always_comb begin
        ovf_any = 1'b0;
        for (int s = 0; s < N_MAX; s++) begin
            if (stg_q.k6 || s < N_K4) begin
                raw_m[s] = bf_pm[s];
                dec_m[s] = bf_dec[s];
            end else begin
                raw_m[s] = '0;
                dec_m[s] = 1'b0;
            end
        end
        for (int i = 0; i < N_BF; i++) begin
            if (stg_q.k6 || i < N_BF_K4) begin
                ovf_any = ovf_any | bf_ovf[i];
            end
        end
    end

    acs_norm #(
        .N       (N_MAX),
        .N_SMALL (N_K4)
    ) u_norm (
        .raw     (raw_m),
        .k6      (stg_q.k6),
        .cleaned (pm_next),
        .cleared (norm_hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_q   <= '0;
            dec_q  <= '0;
            v2_q   <= 1'b0;
            k6_2_q <= 1'b0;
        end else begin
            v2_q <= stg_q.vld;
            if (stg_q.vld) begin
                pm_q   <= pm_next;
                dec_q  <= dec_m;
                k6_2_q <= stg_q.k6;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v_q   <= 1'b0;
            out_pm_q  <= '0;
            out_dec_q <= '0;
        end else begin
            out_v_q <= v2_q;
            if (v2_q) begin
                out_pm_q  <= pm_q;
                out_dec_q <= dec_q;
            end
        end
    end

    assign out_valid = out_v_q;
    assign pm_out    = out_pm_q;
    assign dec_out   = out_dec_q;

    logic [N_MAX-1:0] msb_q;
    always_comb begin
        for (int s = 0; s < N_MAX; s++) begin
            msb_q[s] = pm_q[s][PM_W-1];
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q.vld |-> !ovf_any);

    // R7
    norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg_q.vld |=> (k6_2_q ? !(&msb_q) : !(&msb_q[N_K4-1:0])));

    // R6
    k4_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_q.vld && !stg_q.k6) |=> (dec_q[N_MAX-1:N_K4] == '0 && pm_q[N_MAX-1:N_K4] == '0));

    // R9
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stg_q.vld |=> $stable(pm_q));

    // R8
    latency_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v2_q |=> out_valid);

    // R8
    latency_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !v2_q |=> !out_valid);

    // R4
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_q.vld && stg_q.first) |=> (pm_q[0] <= PM_W'(BM_MAX)));

endmodule

// File: tb/dual_k_acs_tb.sv
module dual_k_acs_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TB_S0_K6 = 32'h639C639C;
    localparam logic [31:0] TB_S1_K6 = 32'h9C639C63;
    localparam logic [7:0]  TB_S0_K4 = 8'hB4;
    localparam logic [7:0]  TB_S1_K4 = 8'h4B;
    localparam int          TB_INIT  = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic [2:0]   sym0 = '0;
    logic [2:0]   sym1 = '0;
    logic         out_valid;
    logic [255:0] pm_out;
    logic [31:0]  dec_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string tag = "R10";

    dual_k_acs #(
        .BM_SEL0_K6 (TB_S0_K6),
        .BM_SEL1_K6 (TB_S1_K6),
        .BM_SEL0_K4 (TB_S0_K4),
        .BM_SEL1_K4 (TB_S1_K4),
        .INIT_BIG   (8'(TB_INIT))
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .start     (start),
        .mode      (mode),
        .sym0      (sym0),
        .sym1      (sym1),
        .out_valid (out_valid),
        .pm_out    (pm_out),
        .dec_out   (dec_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    int m_bm[4];
    bit m_v1, m_first1, m_k61, m_md, m_v2;
    int m_pm[32];
    int m_dec[32];
    bit exp_v;
    int exp_pm[32];
    int exp_dec[32];

    function automatic int pick(bit k6, int bf, bit second);
        logic [31:0] t;
        if (k6) t = second ? TB_S1_K6 : TB_S0_K6;
        else    t = second ? 32'(TB_S1_K4) : 32'(TB_S0_K4);
        return int'((t >> (2*bf)) & 32'd3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_v1 = 0; m_first1 = 0; m_k61 = 0; m_md = 0; m_v2 = 0; exp_v = 0;
            for (int s = 0; s < 32; s++) begin
                m_pm[s] = 0; m_dec[s] = 0; exp_pm[s] = 0; exp_dec[s] = 0;
            end
        end else begin
            exp_v = m_v2;
            if (m_v2) begin
                for (int s = 0; s < 32; s++) begin
                    exp_pm[s] = m_pm[s]; exp_dec[s] = m_dec[s];
                end
            end
            m_v2 = m_v1;
            if (m_v1) begin
                int src[32];
                int nxt[32];
                int n;
                bit high;
                n = m_k61 ? 32 : 8;
                for (int s = 0; s < 32; s++) src[s] = m_first1 ? ((s == 0) ? 0 : TB_INIT) : m_pm[s];
                high = 1;
                for (int s = 0; s < 32; s++) begin
                    if (s >= n) begin
                        nxt[s] = 0; m_dec[s] = 0;
                    end else begin
                        int bf, c0, c1;
                        bf = s / 2;
                        c0 = src[bf]       + m_bm[pick(m_k61, bf, (s % 2) == 1)];
                        c1 = src[bf + n/2] + m_bm[pick(m_k61, bf, (s % 2) == 0)];
                        if (c1 < c0) begin nxt[s] = c1; m_dec[s] = 1; end
                        else         begin nxt[s] = c0; m_dec[s] = 0; end
                        if (nxt[s] < 128) high = 0;
                    end
                end
                for (int s = 0; s < 32; s++) m_pm[s] = (high && s < n) ? nxt[s] - 128 : nxt[s];
            end
            m_v1 = in_valid;
            m_first1 = in_valid && start;
            m_k61 = m_first1 ? mode : m_md;
            if (m_first1) m_md = mode;
            m_bm[0] = int'(sym0) + int'(sym1);
            m_bm[1] = int'(sym0) + 7 - int'(sym1);
            m_bm[2] = 7 - int'(sym0) + int'(sym1);
            m_bm[3] = 14 - int'(sym0) - int'(sym1);
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (out_valid !== exp_v) begin
                n_fail++;
                $display("FAIL %s out_valid actual %0b expected %0b at %0t", tag, out_valid, exp_v, $time);
            end
            n_chk++;
            for (int s = 0; s < 32; s++) begin
                if (int'(pm_out[8*s +: 8]) != exp_pm[s]) begin
                    n_fail++;
                    $display("FAIL %s pm state %0d actual %0d expected %0d at %0t", tag, s, pm_out[8*s +: 8], exp_pm[s], $time);
                    break;
                end
            end
            n_chk++;
            for (int s = 0; s < 32; s++) begin
                if (int'(dec_out[s]) != exp_dec[s]) begin
                    n_fail++;
                    $display("FAIL %s dec state %0d actual %0b expected %0d at %0t", tag, s, dec_out[s], exp_dec[s], $time);
                    break;
                end
            end
        end
    end

    task automatic put(bit v, bit st, bit md, int a, int b);
        in_valid = v; start = st; mode = md; sym0 = 3'(a); sym1 = 3'(b);
        @(negedge clk);
    endtask

    task automatic rnd_packet(bit md, int len, bit toggle_mode, int gap_pct);
        put(1, 1, md, $urandom % 8, $urandom % 8);
        for (int k = 1; k < len; k++) begin
            bit v;
            v = (($urandom % 100) >= gap_pct);
            put(v, 0, toggle_mode ? 1'($urandom % 2) : md, $urandom % 8, $urandom % 8);
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) put(0, 0, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        tag = "R10";
        rst_n = 0;
        idle(4);
        rst_n = 1;
        idle(2);

        // R3 R4: ties on the reload step (a+b=7 and a=b), then random
        tag = "R3 R4";
        put(1, 1, 1, 3, 4);
        put(1, 0, 1, 5, 5);
        put(1, 1, 1, 2, 2);
        put(1, 0, 1, 6, 1);
        put(0, 1, 0, 7, 7);
        idle(3);
        put(1, 1, 0, 3, 4);
        put(1, 0, 0, 0, 7);
        idle(4);

        // R1 R2: large trellis, random and extreme symbols
        tag = "R1 R2";
        rnd_packet(1, 60, 0, 0);
        put(1, 0, 1, 0, 0);
        put(1, 0, 1, 7, 7);
        put(1, 0, 1, 0, 7);
        put(1, 0, 1, 7, 0);
        idle(4);

        // R5 R6: small trellis while the mode input wanders
        tag = "R5 R6";
        rnd_packet(0, 80, 1, 0);
        idle(4);

        // R9: gaps in the symbol stream
        tag = "R9";
        rnd_packet(1, 60, 0, 50);
        rnd_packet(0, 60, 0, 50);
        idle(4);

        // R7: long runs that force repeated normalisation
        tag = "R7";
        rnd_packet(1, 300, 0, 0);
        rnd_packet(0, 300, 1, 10);
        idle(4);

        // R5 R8: back-to-back packets alternating mode, then an isolated symbol
        tag = "R5 R8";
        for (int p = 0; p < 6; p++) begin
            put(1, 1, 1'(p % 2), $urandom % 8, $urandom % 8);
            for (int k = 1; k < 7; k++) put(1, 0, 1'((p + 1) % 2), $urandom % 8, $urandom % 8);
        end
        for (int p = 0; p < 4; p++) put(1, 1, 1'(p % 2), $urandom % 8, $urandom % 8);
        idle(5);
        put(1, 1, 1, 6, 2);
        idle(6);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule